// File: doc/BRIEF.md
# Multi-Channel Pulse Width Modulator Bank

The block holds a parameterized number of independent pulse width modulation channels behind a plain 32-bit register port with separate read and write strobes. Every channel owns a 0x20-byte window with a period word, a duty word, a spare storage word and a control word. It counts the functional clock directly and drives one output pin. The period and duty words are shadows: software may rewrite them at any time, and the running waveform changes only when the enable bit is written with 1 again.

Starting a stopped channel loads the shadows at once, and the waveform begins in its active phase. Recommitting a running channel swaps in the new values at the next period boundary, so no cycle is cut short. The keep bit selects between continuous running and a single period per commit. The polarity bit inverts the pin, including the idle level of a stopped channel.

Top module: `pwm_bank`

## Requirements
- R1: Channel c occupies byte addresses c*0x20 to c*0x20+0x1F, and address bits [1:0] are ignored. Word offset 0x0 holds the period, 0x4 the duty, 0x8 a spare word and 0xC the control word. Control bit 0 is enable, bit 1 is invert and bit 2 is keep. Period, duty and spare read back all 32 written bits. Control reads back bits [2:0] with zeros above them. The read data appears on rdata_o in the cycle after rd_en_i and holds while rd_en_i is low.
- R2: Reads of offsets 0x10 to 0x1C in any window, and of windows for channels at or above NUM_CH, return 0. Writes to those addresses change no register.
- R3: During and after reset, every register is 0 and every pwm_o bit is 0.
- R4: A control write with bit 0 set to a channel that is not running loads the shadow period P and duty D. In the k-th cycle after that write edge (k=0 first), the pin is active when (k mod P) < D.
- R5: Writes to the period or duty word of a running channel leave the waveform unchanged until a commit.
- R6: A control write with bit 0 set to a running channel takes effect at the next period boundary. When the write lands in the last cycle of a period, the following period already uses the new values.
- R7: While a channel is stopped, its pin is at the inactive level, which is 0, or 1 when the invert bit is set. Writing 0 to bit 0 stops the channel from the next cycle.
- R8: When D >= P, the pin is constantly active. When D = 0, it is constantly inactive.
- R9: With keep clear, a channel runs one period and then stops with bit 0 still reading 1. The next commit restarts it at k=0. With keep set, the channel repeats periods indefinitely.
- R10: Channels run independently, each with its own phase and settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock, also the PWM time base |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| pwm_o | output | NUM_CH | One PWM pin per channel |

## Verification
A register write takes effect at the clock edge that samples the strobe, and read data is due one cycle after rd_en_i. The pin follows the new state in the first cycle after the edge, which the bench numbers as k=0. The bench drives and samples on the falling edge. Every bus task advances exactly one cycle and steps a per-channel cycle counter, so each expected level comes from (k mod P) < D at a known k. For a commit on a running channel, the switchover cycle is the first multiple of the old period after the write cycle, and the bench computes that multiple.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned WIN_LG = 5;
  localparam logic [2:0] W_PERIOD = 3'd0;
  localparam logic [2:0] W_DUTY   = 3'd1;
  localparam logic [2:0] W_SPARE  = 3'd2;
  localparam logic [2:0] W_CTRL   = 3'd3;

  typedef struct packed {
    logic keep;
    logic inv;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_CH-1:0][DW-1:0]  chan_rword_i,
  output logic [NUM_CH-1:0]          ch_wr_o,
  output logic [2:0]                 word_o,
  output logic [DW-1:0]              rdata_o
);
  localparam int unsigned CH_W = ADDR_W - WIN_LG;

  logic [CH_W-1:0] ch_idx;
  logic            hit;
  logic [DW-1:0]   rd_sel;

  assign ch_idx = addr_i[ADDR_W-1:WIN_LG];
  assign word_o = addr_i[WIN_LG-1:2];
  assign hit    = (32'(ch_idx) < NUM_CH) && !word_o[2];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign ch_wr_o[c] = wr_en_i && hit && (32'(ch_idx) == c);
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit && (32'(ch_idx) == c)) rd_sel = chan_rword_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_sel;
  end

  assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !hit |=> rdata_o == '0);
  assert_rdata_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  assert_wr_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr_o));
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    word_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rword_o,
  output logic          pwm_o
);
  logic [DW-1:0] period_q, duty_q, spare_q;
  logic [DW-1:0] act_p_q, act_d_q, cnt_q;
  ctrl_t         ctrl_q, ctrl_wr;
  logic          running_q, pending_q;
  logic          ctrl_we, commit, stop, start, boundary;
  logic [DW:0]   cnt_nx;

  assign ctrl_wr  = ctrl_t'(wdata_i[2:0]);
  assign ctrl_we  = wr_i && (word_i == W_CTRL);
  assign commit   = ctrl_we && ctrl_wr.en;
  assign stop     = ctrl_we && !ctrl_wr.en;
  assign start    = commit && !running_q;
  assign cnt_nx   = {1'b0, cnt_q} + 1'b1;
  assign boundary = running_q && (cnt_nx >= {1'b0, act_p_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      duty_q   <= '0;
      spare_q  <= '0;
      ctrl_q   <= '0;
    end else if (wr_i) begin
      case (word_i)
        W_PERIOD: period_q <= wdata_i;
        W_DUTY:   duty_q   <= wdata_i;
        W_SPARE:  spare_q  <= wdata_i;
        W_CTRL:   ctrl_q   <= ctrl_wr;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_p_q   <= '0;
      act_d_q   <= '0;
      cnt_q     <= '0;
      running_q <= 1'b0;
      pending_q <= 1'b0;
    end else if (stop) begin
      running_q <= 1'b0;
      pending_q <= 1'b0;
      cnt_q     <= '0;
    end else if (start) begin
      act_p_q   <= period_q;
      act_d_q   <= duty_q;
      cnt_q     <= '0;
      running_q <= 1'b1;
      pending_q <= 1'b0;
    end else if (running_q) begin
      if (boundary) begin
        cnt_q <= '0;
        if (pending_q || commit) begin
          act_p_q   <= period_q;
          act_d_q   <= duty_q;
          pending_q <= 1'b0;
        end else if (!ctrl_q.keep) begin
          running_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_nx[DW-1:0];
        if (commit) pending_q <= 1'b1;
      end
    end
  end

  assign pwm_o = (running_q && (cnt_q < act_d_q)) ^ ctrl_q.inv;

  always_comb begin
    case (word_i)
      W_PERIOD: rword_o = period_q;
      W_DUTY:   rword_o = duty_q;
      W_SPARE:  rword_o = spare_q;
      W_CTRL:   rword_o = {{(DW-3){1'b0}}, ctrl_q};
      default:  rword_o = '0;
    endcase
  end

  assert_idle_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_q |-> pwm_o == ctrl_q.inv);
  assert_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> running_q && cnt_q == '0);
  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q && act_p_q != '0 |-> cnt_q < act_p_q);
  assert_hold_mid_period_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q && !boundary && !ctrl_we |=> $stable(act_p_q) && $stable(act_d_q));
  assert_zero_duty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q && act_d_q == '0 |-> pwm_o == ctrl_q.inv);
  assert_single_halt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary && !ctrl_q.keep && !pending_q && !wr_i |=> !running_q);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [NUM_CH-1:0]         ch_wr;
  logic [2:0]                word;
  logic [NUM_CH-1:0][DW-1:0] chan_rword;

  pwm_bank_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DW(DW)) u_decode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .chan_rword_i (chan_rword),
    .ch_wr_o      (ch_wr),
    .word_o       (word),
    .rdata_o      (rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_bank_chan #(.DW(DW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (ch_wr[c]),
      .word_i  (word),
      .wdata_i (wdata_i),
      .rword_o (chan_rword[c]),
      .pwm_o   (pwm_o[c])
    );
  end
endmodule

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;

  int n_chk = 0, n_fail = 0;
  int kc[4];
  bit done = 0;

  always #5 clk = ~clk;

  pwm_bank u_pwm_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  function automatic logic [7:0] ad(int ch, int off);
    return 8'(ch * 32 + off);
  endfunction

  function automatic bit expv(int k, int p, int d, bit inv);
    return ((k % p) < d) ^ inv;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    foreach (kc[i]) kc[i]++;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    tick();
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pin(int ch, int p, int d, bit inv, string req);
    bit e;
    e = expv(kc[ch], p, d, inv);
    chk(pwm[ch] === e, req, 32'(pwm[ch]), 32'(e));
  endtask

  task automatic run_chk(int ch, int p, int d, bit inv, int n, string req);
    wr(ad(ch, 12), 32'(inv) << 1);
    wr(ad(ch, 0), 32'(p));
    wr(ad(ch, 4), 32'(d));
    wr(ad(ch, 12), 32'h5 | (32'(inv) << 1));
    kc[ch] = 0;
    repeat (n) begin
      pin(ch, p, d, inv, req);
      tick();
    end
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, p_w, d_w, s_w;
    int unsigned seed;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    chk(pwm === 4'h0, "R3 pins in reset", 32'(pwm), 0);
    rst_n = 1'b1;
    tick();
    chk(pwm === 4'h0, "R3 pins after reset", 32'(pwm), 0);
    rd(ad(0, 0), v); chk(v === 0, "R3 period reset", v, 0);
    rd(ad(1, 12), v); chk(v === 0, "R3 ctrl reset", v, 0);

    // R1 readback, R7 idle inverted
    p_w = $urandom; d_w = $urandom; s_w = $urandom;
    wr(ad(2, 0), p_w); wr(ad(2, 4), d_w); wr(ad(2, 8), s_w);
    wr(ad(2, 12), 32'hFFFF_FFF6);
    chk(pwm[2] === 1'b1, "R7 idle inverted", 32'(pwm[2]), 1);
    rd(ad(2, 0), v);  chk(v === p_w, "R1 period", v, p_w);
    rd(ad(2, 4), v);  chk(v === d_w, "R1 duty", v, d_w);
    rd(ad(2, 8), v);  chk(v === s_w, "R1 spare", v, s_w);
    rd(ad(2, 12), v); chk(v === 32'h6, "R1 ctrl", v, 32'h6);
    chk(rdata === 32'h6, "R1 hold", rdata, 32'h6);

    // R2 unmapped and absent channels
    wr(ad(2, 16), $urandom);
    rd(ad(2, 16), v); chk(v === 0, "R2 gap read", v, 0);
    rd(ad(2, 8), v);  chk(v === s_w, "R2 gap write ignored", v, s_w);
    wr(8'h80, 32'hA5A5_1234);
    rd(8'h80, v);     chk(v === 0, "R2 absent read", v, 0);
    rd(ad(0, 0), v);  chk(v === 0, "R2 absent write ignored", v, 0);
    wr(ad(2, 12), 0);

    // R4 random configurations on channel 0
    for (int it = 0; it < 8; it++) begin
      int p, d;
      p = 1 + int'($urandom % 10);
      d = int'($urandom % 13);
      run_chk(0, p, d, 1'($urandom), 2 * p + 3, "R4");
    end

    // R8 constant levels
    run_chk(0, 5, 5, 0, 12, "R8 full duty");
    run_chk(0, 5, 9, 1, 12, "R8 over duty inverted");
    run_chk(0, 5, 0, 0, 12, "R8 zero duty");
    wr(ad(0, 12), 0);

    // R5 / R6 shadow and commit on channel 1
    wr(ad(1, 0), 4); wr(ad(1, 4), 1); wr(ad(1, 12), 5);
    kc[1] = 0;
    while (kc[1] < 6) begin pin(1, 4, 1, 0, "R4"); tick(); end
    wr(ad(1, 0), 6); wr(ad(1, 4), 3);
    while (kc[1] < 10) begin pin(1, 4, 1, 0, "R5"); tick(); end
    pin(1, 4, 1, 0, "R5");
    wr(ad(1, 12), 5);            // commit mid-period, switch at k=12
    while (kc[1] < 12) begin pin(1, 4, 1, 0, "R6 old"); tick(); end
    while (kc[1] < 15) begin
      chk(pwm[1] === expv(kc[1] - 12, 6, 3, 0), "R6 new", 32'(pwm[1]),
          32'(expv(kc[1] - 12, 6, 3, 0)));
      tick();
    end
    wr(ad(1, 0), 3); wr(ad(1, 4), 2);
    while (kc[1] <= 23) begin
      chk(pwm[1] === expv(kc[1] - 12, 6, 3, 0), "R5 R6 hold", 32'(pwm[1]),
          32'(expv(kc[1] - 12, 6, 3, 0)));
      if (kc[1] < 23) tick();
      else break;
    end
    wr(ad(1, 12), 5);            // commit in last cycle of period
    while (kc[1] < 33) begin
      chk(pwm[1] === expv(kc[1] - 24, 3, 2, 0), "R6 boundary", 32'(pwm[1]),
          32'(expv(kc[1] - 24, 3, 2, 0)));
      tick();
    end
    wr(ad(1, 12), 0);
    chk(pwm[1] === 1'b0, "R7 stop", 32'(pwm[1]), 0);

    // R9 single period without keep on channel 3
    wr(ad(3, 0), 3); wr(ad(3, 4), 2); wr(ad(3, 12), 1);
    kc[3] = 0;
    while (kc[3] < 8) begin
      bit e;
      e = (kc[3] < 2);
      chk(pwm[3] === e, "R9 single", 32'(pwm[3]), 32'(e));
      tick();
    end
    rd(ad(3, 12), v); chk(v === 1, "R9 enable readback", v, 1);
    wr(ad(3, 12), 1);
    kc[3] = 0;
    while (kc[3] < 5) begin
      bit e;
      e = (kc[3] < 2);
      chk(pwm[3] === e, "R9 restart", 32'(pwm[3]), 32'(e));
      tick();
    end
    wr(ad(3, 12), 2);
    chk(pwm[3] === 1'b1, "R7 inverted idle", 32'(pwm[3]), 1);

    // R10 two channels with different phase
    wr(ad(0, 12), 0); wr(ad(0, 0), 3); wr(ad(0, 4), 1);
    wr(ad(2, 12), 2); wr(ad(2, 0), 5); wr(ad(2, 4), 2);
    wr(ad(0, 12), 5); kc[0] = 0;
    wr(ad(2, 12), 7); kc[2] = 0;
    repeat (15) begin
      pin(0, 3, 1, 0, "R10 ch0");
      pin(2, 5, 2, 1, "R10 ch2");
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule